// File: doc/BRIEF.md
# SD Host Interrupt Status Controller

This block gathers the interrupt events of an SD/SDIO host controller into one sticky status register, qualifies them with a per-bit enable register and drives a single interrupt request line. The command, data, buffer and DMA engines deliver one-cycle event pulses. The block also watches three level signals: command busy, read transfer active and data line active. It turns their falling edges into command-complete and transfer-complete events. A command timeout that belongs to the same command takes precedence, so command-complete is withheld when the timeout is reported.

Software reaches the block through a simple register port: one select bit picks the status view or the enable register. Status bits are cleared by writing ones. An error summary bit is not stored. It is computed from the error field and reads as 1 while any error bit is set. The interrupt line is the registered OR of every status bit masked by its enable.

Top module: `sdh_irq_ctrl`

## Requirements
- R1: After reset, the status view, the enable register and `irq_o` all read 0.
- R2: Each event pulse sets its status bit on the clock edge that samples it, and the bit stays set until software clears it. The bit positions are: DMA 3, buffer write ready 4, buffer read ready 5, card interrupt 8, boot status 10, command timeout 16, command CRC 17, command end bit 18, command index 19, data timeout 20, data CRC 21.
- R3: A 1-to-0 change of `cmd_busy` sets command complete (bit 0). The bit is visible on the edge that first samples `cmd_busy` low.
- R4: If `ev_cmd_tmo` pulses while `cmd_busy` is high, or in the same cycle in which `cmd_busy` falls, the fall does not set bit 0 and bit 16 is set. The next command, marked by a rise of `cmd_busy`, is not affected.
- R5: Transfer complete (bit 1) is set by a fall of `rd_active` when `xfer_is_read` is 1. It is set by a fall of `dat_active` when `xfer_is_read` is 0. A fall of the other signal has no effect.
- R6: A pulse on `ev_gap_stop` sets both block gap (bit 2) and transfer complete (bit 1).
- R7: Bit 15 of the status view reads 1 exactly when any bit from 16 to 24 is set. Writing to bit 15 has no effect.
- R8: With `reg_sel`=0, a write clears each status bit whose data bit is 1 and leaves bits written 0 alone. If a set event and a clear hit the same bit in the same cycle, the bit stays set.
- R9: With `reg_sel`=1, a write loads the enable register. Only the implemented positions are kept (mask 0x003F853F). Unimplemented positions read 0 in both views.
- R10: `irq_o` equals the OR over all bits of (status view AND enable), registered, so it follows the status view by exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_busy | input | 1 | Command line busy level (command inhibit) |
| rd_active | input | 1 | Read transfer active level |
| dat_active | input | 1 | Data line active level |
| xfer_is_read | input | 1 | 1 = read transfer, 0 = write transfer |
| ev_gap_stop | input | 1 | Transfer halted at a block gap |
| ev_dma | input | 1 | DMA event pulse |
| ev_buf_wr | input | 1 | Buffer write ready pulse |
| ev_buf_rd | input | 1 | Buffer read ready pulse |
| ev_card | input | 1 | Card interrupt pulse |
| ev_boot | input | 1 | Boot status received pulse |
| ev_cmd_tmo | input | 1 | Command timeout pulse |
| ev_cmd_crc | input | 1 | Command CRC error pulse |
| ev_cmd_end | input | 1 | Command end bit error pulse |
| ev_cmd_idx | input | 1 | Command index error pulse |
| ev_dat_tmo | input | 1 | Data timeout pulse |
| ev_dat_crc | input | 1 | Data CRC error pulse |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 1 | 0 = status view, 1 = enable register |
| reg_wdata | input | REG_W | Register write data |
| reg_rdata | output | REG_W | Read data of the selected register |
| irq_o | output | 1 | Interrupt request |

## Verification
A wrong bit in the stored status shows in the status view on the next read after the faulty edge. It shows on `irq_o` one cycle later, but only when that bit is enabled. For this reason the sweep runs every event against three enable patterns: its own bit only, every other bit, and the summary bit only. A stale edge-detector or timeout-seen flag is harder to see. It shows only at the next command or transfer end, as a missing or spurious bit 0 or bit 1. The bench therefore runs back-to-back commands with and without timeouts, and checks both transfer directions against both level signals.

// File: rtl/sdh_irq_pkg.sv
package sdh_irq_pkg;

    localparam int BIT_CMD_DONE  = 0;
    localparam int BIT_XFER_DONE = 1;
    localparam int BIT_GAP       = 2;
    localparam int BIT_DMA       = 3;
    localparam int BIT_BUF_WR    = 4;
    localparam int BIT_BUF_RD    = 5;
    localparam int BIT_CARD      = 8;
    localparam int BIT_BOOT      = 10;
    localparam int BIT_ERR_SUM   = 15;
    localparam int BIT_CMD_TMO   = 16;
    localparam int BIT_CMD_CRC   = 17;
    localparam int BIT_CMD_END   = 18;
    localparam int BIT_CMD_IDX   = 19;
    localparam int BIT_DAT_TMO   = 20;
    localparam int BIT_DAT_CRC   = 21;
    localparam int ERR_FIELD_HI  = 24;
    localparam int MIN_REG_W     = ERR_FIELD_HI + 1;

    // every implemented position (stored bits plus the computed summary)
    function automatic logic [63:0] impl_mask();
        logic [63:0] m;
        m = '0;
        for (int i = BIT_CMD_DONE; i <= BIT_BUF_RD; i++) m[i] = 1'b1;
        m[BIT_CARD]    = 1'b1;
        m[BIT_BOOT]    = 1'b1;
        m[BIT_ERR_SUM] = 1'b1;
        for (int i = BIT_CMD_TMO; i <= BIT_DAT_CRC; i++) m[i] = 1'b1;
        return m;
    endfunction

    typedef struct packed {
        logic busy_p;
        logic rd_p;
        logic wr_p;
        logic tmo_seen;
    } edge_state_t;

endpackage

// File: rtl/sdh_irq_events.sv
module sdh_irq_events
    import sdh_irq_pkg::*;
#(
    parameter int REG_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_busy,
    input  logic             rd_active,
    input  logic             dat_active,
    input  logic             xfer_is_read,
    input  logic             ev_gap_stop,
    input  logic             ev_dma,
    input  logic             ev_buf_wr,
    input  logic             ev_buf_rd,
    input  logic             ev_card,
    input  logic             ev_boot,
    input  logic             ev_cmd_tmo,
    input  logic             ev_cmd_crc,
    input  logic             ev_cmd_end,
    input  logic             ev_cmd_idx,
    input  logic             ev_dat_tmo,
    input  logic             ev_dat_crc,
    output logic [REG_W-1:0] set_o
);

    edge_state_t st_d, st_q;
    logic        busy_rise;
    logic        busy_fall;
    logic        cmd_done;
    logic        xfer_done;

    always_comb begin
        st_d        = st_q;
        st_d.busy_p = cmd_busy;
        st_d.rd_p   = rd_active;
        st_d.wr_p   = dat_active;

        busy_rise = cmd_busy & ~st_q.busy_p;
        busy_fall = ~cmd_busy & st_q.busy_p;

        // a new command starts with no timeout recorded
        if (busy_rise) st_d.tmo_seen = 1'b0;
        if (ev_cmd_tmo && cmd_busy) st_d.tmo_seen = 1'b1;

        cmd_done  = busy_fall & ~ev_cmd_tmo & ~st_q.tmo_seen;
        xfer_done = xfer_is_read ? (st_q.rd_p & ~rd_active)
                                 : (st_q.wr_p & ~dat_active);

        set_o                = '0;
        set_o[BIT_CMD_DONE]  = cmd_done;
        set_o[BIT_XFER_DONE] = xfer_done | ev_gap_stop;
        set_o[BIT_GAP]       = ev_gap_stop;
        set_o[BIT_DMA]       = ev_dma;
        set_o[BIT_BUF_WR]    = ev_buf_wr;
        set_o[BIT_BUF_RD]    = ev_buf_rd;
        set_o[BIT_CARD]      = ev_card;
        set_o[BIT_BOOT]      = ev_boot;
        set_o[BIT_CMD_TMO]   = ev_cmd_tmo;
        set_o[BIT_CMD_CRC]   = ev_cmd_crc;
        set_o[BIT_CMD_END]   = ev_cmd_end;
        set_o[BIT_CMD_IDX]   = ev_cmd_idx;
        set_o[BIT_DAT_TMO]   = ev_dat_tmo;
        set_o[BIT_DAT_CRC]   = ev_dat_crc;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

endmodule

// File: rtl/sdh_irq_regs.sv
module sdh_irq_regs
    import sdh_irq_pkg::*;
#(
    parameter int REG_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [REG_W-1:0] set_i,
    input  logic             reg_wr,
    input  logic             reg_sel,
    input  logic [REG_W-1:0] reg_wdata,
    output logic [REG_W-1:0] reg_rdata,
    output logic [REG_W-1:0] stat_view_o,
    output logic [REG_W-1:0] en_o
);

    localparam logic [63:0]      FULL_MASK  = impl_mask();
    localparam logic [REG_W-1:0] IMPL_MASK  = FULL_MASK[REG_W-1:0];
    localparam logic [REG_W-1:0] STORE_MASK = IMPL_MASK & ~(REG_W'(1) << BIT_ERR_SUM);

    typedef struct packed {
        logic [REG_W-1:0] stat;
        logic [REG_W-1:0] en;
    } regs_t;

    regs_t            r_d, r_q;
    logic [REG_W-1:0] clr_vec;
    logic             err_sum;

    always_comb begin
        r_d     = r_q;
        clr_vec = (reg_wr && !reg_sel) ? reg_wdata : '0;
        // a set in the same cycle as a clear keeps the bit
        r_d.stat = ((r_q.stat & ~clr_vec) | set_i) & STORE_MASK;
        if (reg_wr && reg_sel) r_d.en = reg_wdata & IMPL_MASK;

        err_sum                  = |r_q.stat[ERR_FIELD_HI:BIT_ERR_SUM+1];
        stat_view_o              = r_q.stat;
        stat_view_o[BIT_ERR_SUM] = err_sum;
        en_o                     = r_q.en;
        reg_rdata                = reg_sel ? r_q.en : stat_view_o;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

endmodule

// File: rtl/sdh_irq_req.sv
module sdh_irq_req #(
    parameter int REG_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [REG_W-1:0] stat_i,
    input  logic [REG_W-1:0] en_i,
    output logic             irq_o
);

    logic irq_d, irq_q;

    always_comb begin
        irq_d = |(stat_i & en_i);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) irq_q <= 1'b0;
        else        irq_q <= irq_d;
    end

    assign irq_o = irq_q;

endmodule

// File: rtl/sdh_irq_ctrl.sv
module sdh_irq_ctrl
    import sdh_irq_pkg::*;
#(
    parameter int REG_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_busy,
    input  logic             rd_active,
    input  logic             dat_active,
    input  logic             xfer_is_read,
    input  logic             ev_gap_stop,
    input  logic             ev_dma,
    input  logic             ev_buf_wr,
    input  logic             ev_buf_rd,
    input  logic             ev_card,
    input  logic             ev_boot,
    input  logic             ev_cmd_tmo,
    input  logic             ev_cmd_crc,
    input  logic             ev_cmd_end,
    input  logic             ev_cmd_idx,
    input  logic             ev_dat_tmo,
    input  logic             ev_dat_crc,
    input  logic             reg_wr,
    input  logic             reg_sel,
    input  logic [REG_W-1:0] reg_wdata,
    output logic [REG_W-1:0] reg_rdata,
    output logic             irq_o
);

    logic [REG_W-1:0] set_w;
    logic [REG_W-1:0] stat_w;
    logic [REG_W-1:0] en_w;

    generate
        if (REG_W < MIN_REG_W) begin : g_bad_width
            initial $error("REG_W must cover the error field");
        end
    endgenerate

    sdh_irq_events #(.REG_W(REG_W)) events_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .cmd_busy     (cmd_busy),
        .rd_active    (rd_active),
        .dat_active   (dat_active),
        .xfer_is_read (xfer_is_read),
        .ev_gap_stop  (ev_gap_stop),
        .ev_dma       (ev_dma),
        .ev_buf_wr    (ev_buf_wr),
        .ev_buf_rd    (ev_buf_rd),
        .ev_card      (ev_card),
        .ev_boot      (ev_boot),
        .ev_cmd_tmo   (ev_cmd_tmo),
        .ev_cmd_crc   (ev_cmd_crc),
        .ev_cmd_end   (ev_cmd_end),
        .ev_cmd_idx   (ev_cmd_idx),
        .ev_dat_tmo   (ev_dat_tmo),
        .ev_dat_crc   (ev_dat_crc),
        .set_o        (set_w)
    );

    sdh_irq_regs #(.REG_W(REG_W)) regs_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .set_i       (set_w),
        .reg_wr      (reg_wr),
        .reg_sel     (reg_sel),
        .reg_wdata   (reg_wdata),
        .reg_rdata   (reg_rdata),
        .stat_view_o (stat_w),
        .en_o        (en_w)
    );

    sdh_irq_req #(.REG_W(REG_W)) req_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .stat_i (stat_w),
        .en_i   (en_w),
        .irq_o  (irq_o)
    );

endmodule

// File: rtl/sdh_irq_chk.sv
module sdh_irq_chk
    import sdh_irq_pkg::*;
#(
    parameter int REG_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cmd_busy,
    input logic             ev_cmd_tmo,
    input logic             ev_buf_rd,
    input logic             reg_wr,
    input logic             reg_sel,
    input logic [REG_W-1:0] reg_wdata,
    input logic [REG_W-1:0] stat,
    input logic [REG_W-1:0] en,
    input logic             irq
);

    p_rst_clean_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (stat == '0 && en == '0 && !irq));

    p_sticky_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (stat[BIT_BUF_RD] && !(reg_wr && !reg_sel && reg_wdata[BIT_BUF_RD]))
        |=> stat[BIT_BUF_RD]);

    p_cc_from_fall_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stat[BIT_CMD_DONE]) |-> ($past(cmd_busy, 2) && !$past(cmd_busy)));

    p_tmo_over_cc_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stat[BIT_CMD_DONE]) |-> !$past(ev_cmd_tmo));

    p_sum_follows_r7: assert property (@(posedge clk) disable iff (!rst_n)
        stat[BIT_ERR_SUM] == (|stat[ERR_FIELD_HI:BIT_ERR_SUM+1]));

    p_w1c_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && !reg_sel && reg_wdata[BIT_CMD_TMO] && !ev_cmd_tmo)
        |=> !stat[BIT_CMD_TMO]);

    p_irq_latency_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (irq == $past(|(stat & en))));

endmodule

bind sdh_irq_ctrl sdh_irq_chk #(.REG_W(REG_W)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmd_busy   (cmd_busy),
    .ev_cmd_tmo (ev_cmd_tmo),
    .ev_buf_rd  (ev_buf_rd),
    .reg_wr     (reg_wr),
    .reg_sel    (reg_sel),
    .reg_wdata  (reg_wdata),
    .stat       (stat_w),
    .en         (en_w),
    .irq        (irq_o)
);

// File: tb/sdh_irq_ctrl_tb_top.sv
module sdh_irq_ctrl_tb_top;

    localparam int REG_W = 32;
    localparam logic [31:0] IMPL = 32'h003F853F;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cmd_busy = 0, rd_active = 0, dat_active = 0, xfer_is_read = 0;
    logic ev_gap_stop = 0, ev_dma = 0, ev_buf_wr = 0, ev_buf_rd = 0, ev_card = 0;
    logic ev_boot = 0, ev_cmd_tmo = 0, ev_cmd_crc = 0, ev_cmd_end = 0;
    logic ev_cmd_idx = 0, ev_dat_tmo = 0, ev_dat_crc = 0;
    logic reg_wr = 0, reg_sel = 0;
    logic [REG_W-1:0] reg_wdata = '0;
    logic [REG_W-1:0] reg_rdata;
    logic irq_o;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 0;

    always #4 clk = ~clk;

    sdh_irq_ctrl #(.REG_W(REG_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .cmd_busy(cmd_busy), .rd_active(rd_active),
        .dat_active(dat_active), .xfer_is_read(xfer_is_read),
        .ev_gap_stop(ev_gap_stop), .ev_dma(ev_dma), .ev_buf_wr(ev_buf_wr),
        .ev_buf_rd(ev_buf_rd), .ev_card(ev_card), .ev_boot(ev_boot),
        .ev_cmd_tmo(ev_cmd_tmo), .ev_cmd_crc(ev_cmd_crc), .ev_cmd_end(ev_cmd_end),
        .ev_cmd_idx(ev_cmd_idx), .ev_dat_tmo(ev_dat_tmo), .ev_dat_crc(ev_dat_crc),
        .reg_wr(reg_wr), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .irq_o(irq_o)
    );

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic int ev_pos(input int idx);
        case (idx)
            0: return 3;   1: return 4;   2: return 5;   3: return 8;
            4: return 10;  5: return 16;  6: return 17;  7: return 18;
            8: return 19;  9: return 20;  default: return 21;
        endcase
    endfunction

    function automatic logic [31:0] view_of(input int pos);
        logic [31:0] v;
        v = 32'h1 << pos;
        if (pos >= 16 && pos <= 24) v[15] = 1'b1;
        return v;
    endfunction

    task automatic set_ev(input int idx, input logic v);
        case (idx)
            0: ev_dma = v;      1: ev_buf_wr = v;   2: ev_buf_rd = v;
            3: ev_card = v;     4: ev_boot = v;     5: ev_cmd_tmo = v;
            6: ev_cmd_crc = v;  7: ev_cmd_end = v;  8: ev_cmd_idx = v;
            9: ev_dat_tmo = v;  default: ev_dat_crc = v;
        endcase
    endtask

    task automatic wr_reg(input logic sel, input logic [31:0] d);
        reg_wr = 1; reg_sel = sel; reg_wdata = d;
        tick();
        reg_wr = 0; reg_sel = 0; reg_wdata = '0;
    endtask

    task automatic rd_reg(input logic sel, output logic [31:0] d);
        reg_sel = sel;
        #1 d = reg_rdata;
        reg_sel = 0;
    endtask

    task automatic clear_all();
        wr_reg(0, 32'hFFFF_FFFF);
        tick();
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin : main
        logic [31:0] v;
        repeat (3) tick();
        rst_n = 1;
        tick();

        // R1 reset state
        rd_reg(0, v); check("R1 status", v, 32'h0);
        rd_reg(1, v); check("R1 enable", v, 32'h0);
        check("R1 irq", {31'h0, irq_o}, 32'h0);

        // R9 enable register mask and unimplemented status bits
        wr_reg(1, 32'hFFFF_FFFF);
        rd_reg(1, v); check("R9 enable mask", v, IMPL);
        wr_reg(1, 32'h0);
        rd_reg(1, v); check("R9 enable cleared", v, 32'h0);

        // R2 R7 R8 R10 sweep: every event under three enable patterns
        for (int idx = 0; idx < 11; idx++) begin
            for (int mode = 0; mode < 3; mode++) begin
                int pos;
                logic [31:0] en, exp;
                logic exp_irq;
                pos = ev_pos(idx);
                exp = view_of(pos);
                case (mode)
                    0: en = 32'h1 << pos;
                    1: en = IMPL & ~(32'h1 << pos) & ~32'h8000;
                    default: en = 32'h8000;
                endcase
                exp_irq = |(exp & en);
                wr_reg(1, en);
                set_ev(idx, 1);
                tick();
                set_ev(idx, 0);
                rd_reg(0, v); check("R2 event sets bit", v, exp);
                check("R10 irq not yet", {31'h0, irq_o}, 32'h0);
                tick();
                check("R10 irq after one cycle", {31'h0, irq_o}, {31'h0, exp_irq});
                rd_reg(0, v); check("R2 sticky", v, exp);
                // R8 writing zeros does nothing, R7 write to summary ignored
                wr_reg(0, ~(32'h1 << pos) & ~32'h8000);
                rd_reg(0, v); check("R8 write zero no effect", v, exp);
                wr_reg(0, 32'h8000);
                rd_reg(0, v); check("R7 summary write ignored", v, exp);
                wr_reg(0, 32'h1 << pos);
                rd_reg(0, v); check("R8 w1c clears", v, 32'h0);
                tick();
                check("R10 irq drops", {31'h0, irq_o}, 32'h0);
            end
        end
        wr_reg(1, 32'h0);

        // R7 summary persists until the last error bit is cleared
        ev_cmd_crc = 1; ev_dat_crc = 1; tick(); ev_cmd_crc = 0; ev_dat_crc = 0;
        wr_reg(0, 32'h1 << 17);
        rd_reg(0, v); check("R7 summary with one error left", v, 32'h0020_8000);
        wr_reg(0, 32'h1 << 21);
        rd_reg(0, v); check("R7 summary clears", v, 32'h0);

        // R8 set wins over clear in the same cycle
        ev_dma = 1; reg_wr = 1; reg_sel = 0; reg_wdata = 32'h8;
        tick();
        ev_dma = 0; reg_wr = 0; reg_wdata = '0;
        rd_reg(0, v); check("R8 set beats clear", v, 32'h8);
        clear_all();

        // R3 plain command complete
        cmd_busy = 1; tick(); tick();
        cmd_busy = 0; tick();
        rd_reg(0, v); check("R3 command complete on fall", v, 32'h1);
        tick();
        rd_reg(0, v); check("R3 no second set", v, 32'h1);
        clear_all();

        // R4 timeout during the command
        cmd_busy = 1; tick();
        ev_cmd_tmo = 1; tick(); ev_cmd_tmo = 0; tick();
        cmd_busy = 0; tick();
        rd_reg(0, v); check("R4 timeout suppresses complete", v, 32'h0001_8000);
        clear_all();

        // R4 timeout in the same cycle as the fall
        cmd_busy = 1; tick(); tick();
        cmd_busy = 0; ev_cmd_tmo = 1; tick(); ev_cmd_tmo = 0;
        rd_reg(0, v); check("R4 same-cycle timeout", v, 32'h0001_8000);
        clear_all();

        // R4 next command unaffected
        cmd_busy = 1; tick(); tick();
        cmd_busy = 0; tick();
        rd_reg(0, v); check("R4 next command completes", v, 32'h1);
        clear_all();

        // R5 read mode
        xfer_is_read = 1;
        rd_active = 1; dat_active = 1; tick(); tick();
        dat_active = 0; tick(); tick();
        rd_reg(0, v); check("R5 read mode ignores data line", v, 32'h0);
        rd_active = 0; tick();
        rd_reg(0, v); check("R5 read mode completes", v, 32'h2);
        clear_all();

        // R5 write mode
        xfer_is_read = 0;
        rd_active = 1; dat_active = 1; tick(); tick();
        rd_active = 0; tick(); tick();
        rd_reg(0, v); check("R5 write mode ignores read active", v, 32'h0);
        dat_active = 0; tick();
        rd_reg(0, v); check("R5 write mode completes", v, 32'h2);
        clear_all();

        // R6 block gap stop
        ev_gap_stop = 1; tick(); ev_gap_stop = 0;
        rd_reg(0, v); check("R6 gap sets gap and transfer", v, 32'h6);
        wr_reg(1, 32'h4); tick();
        check("R6 R10 gap irq", {31'h0, irq_o}, 32'h1);
        clear_all();
        wr_reg(1, 32'h0);

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule